// File: doc/BRIEF.md
# Cell-Framed Queue Write Controller

This block sits on the write side of one input queue of a cell multiplexer. It takes 9-bit words from an upstream agent under a three-wire handshake made of cell-available, enable and start-of-cell. It then decides, word by word, whether each word is stored. Words are grouped into cells of a size programmed at reset. A cell is opened only by a proper start mark, and it is closed after exactly the programmed number of words. Misplaced marks and surplus words are discarded, so the queue framing recovers by itself from short and long cells.

A mode strap selects the signalling direction. In receive mode the upstream agent asserts cell-available, and the block drives enable to pull words in. In transmit mode the upstream agent drives enable, and the block drives cell-available to advertise room for a whole cell. The block tracks the queue's byte occupancy and its count of complete cells. It raises a cell-ready flag for the read side, which returns a one-cycle pop pulse for each cell it consumes. The storage array and the output scheduler are separate blocks. This block hands each accepted word to storage through a registered write strobe and data.

Top module: `cell_ingress_ctrl`

## Requirements
- R1: While `rst` is high the cell length is loaded from `size_code` (bit 0 least significant). Code 0 means 128 words, codes 1 to 7 are raised to 8, and any other code is the length itself. Changes to `size_code` after reset have no effect.
- R2: When `use_dflt` is high during reset, the cell length is 53 whatever `size_code` holds.
- R3: Outside a cell, a word is stored only if it is offered with `soc_in` high and cell-available asserted. Offered words without both are dropped, and `wr_en_o` stays low.
- R4: Each cell stores exactly the programmed number of words. `cell_ready_o` rises on the edge that stores the last word, and later words are blocked until a new start.
- R5: A `soc_in` pulse inside an open cell is ignored. The words of that following cell complete the current cell, its surplus words are dropped, and the cell after it frames correctly.
- R6: Words offered after a cell has completed, with no new start mark, are discarded.
- R7: In receive mode (`tx_mode`=0) `en_out` is driven high while a cell is open or a whole cell of space is free. A word is stored on an edge at which `en_out` is high and either `cav_in` is high or a cell is open. `en_in` is ignored, and `en_out` is never high in transmit mode.
- R8: In transmit mode `cav_out` is high only when a whole cell of space is free. A word is stored only on an edge with `en_in` high, so a low `en_in` mid-cell pauses the cell. `cav_out` is never high in receive mode.
- R9: `cell_ready_o` is high whenever at least one complete cell is held. Each `cell_pop` pulse removes one cell and its words, and a pop with no complete cell held is ignored. All outputs are low during reset.
- R10: The queue holds at most DEPTH (128) words. Once fewer than one cell length of words is free, `en_out` and `cav_out` fall on the edge that stores the filling word and rise on the edge of the pop that frees the room.
- R11: `wr_data_o` presents the stored word in the cycle after the edge that accepts it, together with `wr_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst | input | 1 | Synchronous active-high reset; cell length is captured while high |
| tx_mode | input | 1 | Signalling direction strap: 0 receive, 1 transmit |
| use_dflt | input | 1 | Selects the fixed 53-word cell length at reset |
| size_code | input | 7 | Programmed cell length code, sampled during reset |
| cav_in | input | 1 | Cell-available from the upstream agent (receive mode) |
| en_in | input | 1 | Enable from the upstream agent (transmit mode) |
| soc_in | input | 1 | Start-of-cell mark on the first word |
| data_in | input | 9 | Incoming word |
| cell_pop | input | 1 | Read side consumed one complete cell |
| en_out | output | 1 | Enable to the upstream agent (receive mode) |
| cav_out | output | 1 | Room for a whole cell (transmit mode) |
| wr_en_o | output | 1 | Registered write strobe to storage |
| wr_data_o | output | 9 | Registered word to storage |
| cell_ready_o | output | 1 | At least one complete cell is stored |

## Verification
The assertions watch the cycle-level rules. They check that each write strobe traces back to an enable seen on the previous edge in the active mode, and that each handshake output stays silent in the mode that does not own it. They also check that cell-ready rises only with a write and falls only after a pop, and that occupancy never exceeds the depth. Only the bench's scenarios can show the framing itself. That covers the exact word count per cell for the programmed, clamped, all-zero and default lengths, the short-cell absorb and drop sequence, and the long-cell discard. It also covers the room thresholds that close and reopen the handshake and the data that reaches storage.

// File: rtl/cig_pkg.sv
package cig_pkg;
  localparam int CIG_DATA_W    = 9;
  localparam int CIG_SIZE_W    = 7;
  localparam int CIG_DEPTH     = 128;
  localparam int CIG_MIN_CELL  = 8;
  localparam int CIG_DFLT_CELL = 53;

  typedef enum logic {
    FR_HUNT = 1'b0,
    FR_FILL = 1'b1
  } frame_state_e;
endpackage

// File: rtl/cig_size_cfg.sv
module cig_size_cfg import cig_pkg::*; #(
  parameter int SIZE_W    = CIG_SIZE_W,
  parameter int MIN_CELL  = CIG_MIN_CELL,
  parameter int DFLT_CELL = CIG_DFLT_CELL
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              use_dflt,
  input  logic [SIZE_W-1:0] size_code,
  output logic [SIZE_W:0]   cell_len
);
  localparam logic [SIZE_W:0] LEN_MAX = {1'b1, {SIZE_W{1'b0}}};
  localparam logic [SIZE_W:0] LEN_MIN = (SIZE_W+1)'(MIN_CELL);

  logic [SIZE_W:0] decoded;
  logic [SIZE_W:0] chosen;

  always_comb begin
    if (size_code == '0)
      decoded = LEN_MAX;
    else if ({1'b0, size_code} < LEN_MIN)
      decoded = LEN_MIN;
    else
      decoded = {1'b0, size_code};
  end

  generate
    if (DFLT_CELL > 0) begin : g_dflt
      localparam logic [SIZE_W:0] LEN_DFLT = (SIZE_W+1)'(DFLT_CELL);
      assign chosen = use_dflt ? LEN_DFLT : decoded;
    end else begin : g_nodflt
      logic unused_dflt;
      assign unused_dflt = use_dflt;
      assign chosen = decoded;
    end
  endgenerate

  // Continuously reloaded while reset is held; frozen once it is released.
  always_ff @(posedge clk) begin
    if (rst)
      cell_len <= chosen;
  end
endmodule

// File: rtl/cig_framer.sv
module cig_framer import cig_pkg::*; #(
  parameter int SIZE_W = CIG_SIZE_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tx_mode,
  input  logic            en_in,
  input  logic            en_out,
  input  logic            cav_in,
  input  logic            cav_out,
  input  logic            soc_in,
  input  logic [SIZE_W:0] cell_len,
  output logic            accept,
  output logic            cell_done,
  output logic            fill_nxt
);
  localparam logic [SIZE_W:0] ONE = (SIZE_W+1)'(1);

  frame_state_e    st_q;
  logic [SIZE_W:0] cnt_q;
  logic            in_cell;
  logic            offer;
  logic            cav_ok;
  logic            start;

  always_comb begin
    in_cell   = (st_q == FR_FILL);
    // Receive: block owns enable; once a cell is open, cell-available no longer gates.
    offer     = tx_mode ? en_in : (en_out & (cav_in | in_cell));
    cav_ok    = tx_mode ? cav_out : cav_in;
    start     = !rst & !in_cell & offer & soc_in & cav_ok;
    cell_done = !rst & in_cell & offer & (cnt_q == cell_len - ONE);
    accept    = start | (!rst & in_cell & offer);
    fill_nxt  = start | (in_cell & !cell_done);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= FR_HUNT;
      cnt_q <= '0;
    end else if (start) begin
      st_q  <= FR_FILL;
      cnt_q <= ONE;
    end else if (cell_done) begin
      st_q  <= FR_HUNT;
      cnt_q <= '0;
    end else if (accept) begin
      cnt_q <= cnt_q + ONE;
    end
  end
endmodule

// File: rtl/cig_space.sv
module cig_space import cig_pkg::*; #(
  parameter int DEPTH    = CIG_DEPTH,
  parameter int SIZE_W   = CIG_SIZE_W,
  parameter int MIN_CELL = CIG_MIN_CELL,
  parameter int OCC_W    = $clog2(DEPTH + 1),
  parameter int CELLS_W  = $clog2(DEPTH / MIN_CELL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             done,
  input  logic             pop,
  input  logic [SIZE_W:0]  cell_len,
  output logic [OCC_W-1:0] occ_q,
  output logic             room_nxt,
  output logic             ready_q
);
  logic [CELLS_W-1:0] cells_q;
  logic [CELLS_W-1:0] cells_nxt;
  logic [OCC_W:0]     occ_sum;
  logic [OCC_W-1:0]   occ_nxt;
  logic [OCC_W+1:0]   need;
  logic               pop_ok;

  always_comb begin
    pop_ok    = pop & (cells_q != '0);
    occ_sum   = {1'b0, occ_q} + (OCC_W+1)'(wr)
              - (pop_ok ? (OCC_W+1)'(cell_len) : '0);
    occ_nxt   = occ_sum[OCC_W-1:0];
    cells_nxt = cells_q + CELLS_W'(done) - CELLS_W'(pop_ok);
    need      = (OCC_W+2)'(occ_nxt) + (OCC_W+2)'(cell_len);
    room_nxt  = (need <= (OCC_W+2)'(DEPTH));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q   <= '0;
      cells_q <= '0;
      ready_q <= 1'b0;
    end else begin
      occ_q   <= occ_nxt;
      cells_q <= cells_nxt;
      ready_q <= (cells_nxt != '0);
    end
  end
endmodule

// File: rtl/cell_ingress_ctrl.sv
module cell_ingress_ctrl import cig_pkg::*; #(
  parameter int DATA_W    = CIG_DATA_W,
  parameter int SIZE_W    = CIG_SIZE_W,
  parameter int DEPTH     = CIG_DEPTH,
  parameter int MIN_CELL  = CIG_MIN_CELL,
  parameter int DFLT_CELL = CIG_DFLT_CELL
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_mode,
  input  logic              use_dflt,
  input  logic [SIZE_W-1:0] size_code,
  input  logic              cav_in,
  input  logic              en_in,
  input  logic              soc_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              cell_pop,
  output logic              en_out,
  output logic              cav_out,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              cell_ready_o
);
  localparam int OCC_W   = $clog2(DEPTH + 1);
  localparam int CELLS_W = $clog2(DEPTH / MIN_CELL + 1);

  logic [SIZE_W:0]  cell_len;
  logic             accept;
  logic             cell_done;
  logic             fill_nxt;
  logic [OCC_W-1:0] occ_q;
  logic             room_nxt;

  cig_size_cfg #(
    .SIZE_W(SIZE_W), .MIN_CELL(MIN_CELL), .DFLT_CELL(DFLT_CELL)
  ) u_cfg (
    .clk(clk), .rst(rst), .use_dflt(use_dflt),
    .size_code(size_code), .cell_len(cell_len)
  );

  cig_framer #(.SIZE_W(SIZE_W)) u_frm (
    .clk(clk), .rst(rst), .tx_mode(tx_mode),
    .en_in(en_in), .en_out(en_out), .cav_in(cav_in), .cav_out(cav_out),
    .soc_in(soc_in), .cell_len(cell_len),
    .accept(accept), .cell_done(cell_done), .fill_nxt(fill_nxt)
  );

  cig_space #(
    .DEPTH(DEPTH), .SIZE_W(SIZE_W), .MIN_CELL(MIN_CELL),
    .OCC_W(OCC_W), .CELLS_W(CELLS_W)
  ) u_spc (
    .clk(clk), .rst(rst), .wr(accept), .done(cell_done), .pop(cell_pop),
    .cell_len(cell_len), .occ_q(occ_q), .room_nxt(room_nxt),
    .ready_q(cell_ready_o)
  );

  // Handshake flags use next-state occupancy so they never lag a write or pop.
  always_ff @(posedge clk) begin
    if (rst) begin
      en_out    <= 1'b0;
      cav_out   <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_data_o <= '0;
    end else begin
      en_out    <= !tx_mode & (fill_nxt | room_nxt);
      cav_out   <= tx_mode & room_nxt;
      wr_en_o   <= accept;
      wr_data_o <= data_in;
    end
  end
endmodule

// File: rtl/cig_checker.sv
module cig_checker #(
  parameter int DEPTH = 128,
  parameter int OCC_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_mode,
  input logic             en_in,
  input logic             en_out,
  input logic             cav_out,
  input logic             wr_en_o,
  input logic             cell_ready_o,
  input logic             cell_pop,
  input logic [OCC_W-1:0] occ
);
  p_en_only_rx_r7: assert property (@(posedge clk) disable iff (rst)
    tx_mode |-> !en_out);

  p_cav_only_tx_r8: assert property (@(posedge clk) disable iff (rst)
    !tx_mode |-> !cav_out);

  p_write_follows_enable_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> $past(tx_mode ? en_in : en_out));

  p_ready_rise_with_write_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(cell_ready_o) |-> wr_en_o);

  p_ready_fall_after_pop_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(cell_ready_o) |-> $past(cell_pop));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    occ <= OCC_W'(DEPTH));
endmodule

bind cell_ingress_ctrl cig_checker #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_chk (
  .clk(clk), .rst(rst), .tx_mode(tx_mode), .en_in(en_in), .en_out(en_out),
  .cav_out(cav_out), .wr_en_o(wr_en_o), .cell_ready_o(cell_ready_o),
  .cell_pop(cell_pop), .occ(occ_q)
);

// File: tb/tb_cell_ingress_ctrl.sv
module tb_cell_ingress_ctrl;
  logic       clk = 1'b0;
  logic       rst, tx_mode, use_dflt, cav_in, en_in, soc_in, cell_pop;
  logic [6:0] size_code;
  logic [8:0] data_in;
  logic       en_out, cav_out, wr_en_o, cell_ready_o;
  logic [8:0] wr_data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cell_ingress_ctrl dut (
    .clk(clk), .rst(rst), .tx_mode(tx_mode), .use_dflt(use_dflt),
    .size_code(size_code), .cav_in(cav_in), .en_in(en_in), .soc_in(soc_in),
    .data_in(data_in), .cell_pop(cell_pop), .en_out(en_out), .cav_out(cav_out),
    .wr_en_o(wr_en_o), .wr_data_o(wr_data_o), .cell_ready_o(cell_ready_o)
  );

  // Entry: {en_in, soc_in, expected wr_en_o, expected cell_ready_o, data}
  // Transmit mode, cell length 8.
  localparam int NV = 33;
  localparam logic [12:0] TBL [NV] = '{
    {4'b1110, 9'h100}, {4'b1010, 9'h001}, {4'b1010, 9'h002}, {4'b1010, 9'h003},
    {4'b1010, 9'h004}, {4'b1010, 9'h005}, {4'b1010, 9'h006}, {4'b1011, 9'h007},
    {4'b1001, 9'h0AA}, {4'b1001, 9'h0AB},
    {4'b1111, 9'h110}, {4'b1011, 9'h011}, {4'b1011, 9'h012}, {4'b0001, 9'h1FF},
    {4'b1011, 9'h013},
    {4'b1111, 9'h120}, {4'b1011, 9'h021}, {4'b1011, 9'h022}, {4'b1011, 9'h023},
    {4'b1001, 9'h024}, {4'b1001, 9'h025}, {4'b1001, 9'h026}, {4'b1001, 9'h027},
    {4'b1111, 9'h130}, {4'b1011, 9'h031}, {4'b1011, 9'h032}, {4'b1011, 9'h033},
    {4'b1011, 9'h034}, {4'b1011, 9'h035}, {4'b1011, 9'h036}, {4'b1011, 9'h037},
    {4'b1001, 9'h038}, {4'b1001, 9'h039}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic en, input logic cav, input logic soc, input logic [8:0] d);
    en_in = en; cav_in = cav; soc_in = soc; data_in = d; cell_pop = 1'b0;
    tick();
  endtask

  task automatic pop_one();
    en_in = 0; cav_in = 0; soc_in = 0; cell_pop = 1'b1;
    tick();
    cell_pop = 1'b0;
  endtask

  task automatic start_up(input logic tx, input logic dflt, input logic [6:0] code);
    rst = 1; tx_mode = tx; use_dflt = dflt; size_code = code;
    en_in = 0; cav_in = 0; soc_in = 0; data_in = '0; cell_pop = 0;
    tick(); tick();
    rst = 0;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // Reset state, R9
    rst = 1; tx_mode = 1; use_dflt = 0; size_code = 7'd8;
    en_in = 1; cav_in = 1; soc_in = 1; data_in = 9'h1AA; cell_pop = 0;
    tick(); tick();
    chk({en_out, cav_out, wr_en_o, cell_ready_o} == 4'b0, "R9 reset outputs",
        {en_out, cav_out, wr_en_o, cell_ready_o}, 0);
    en_in = 0; cav_in = 0; soc_in = 0;
    rst = 0;
    tick();
    chk(cav_out == 1'b1, "R8 cav_out with room", cav_out, 1);
    chk(en_out == 1'b0, "R7 en_out low in tx", en_out, 0);

    // Vector table: R3 R4 R5 R6 R8 R11
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i][12], 1'b0, TBL[i][11], TBL[i][8:0]);
      chk(wr_en_o == TBL[i][10], $sformatf("R5 R6 R8 framing vec %0d", i), wr_en_o, TBL[i][10]);
      chk(cell_ready_o == TBL[i][9], $sformatf("R4 ready vec %0d", i), cell_ready_o, TBL[i][9]);
      if (TBL[i][10])
        chk(wr_data_o == TBL[i][8:0], $sformatf("R11 data vec %0d", i), wr_data_o, TBL[i][8:0]);
    end

    // Pops: three cells held, R9
    pop_one();
    pop_one();
    chk(cell_ready_o == 1'b1, "R9 one cell left", cell_ready_o, 1);
    pop_one();
    chk(cell_ready_o == 1'b0, "R9 all cells popped", cell_ready_o, 0);
    pop_one();
    chk(cell_ready_o == 1'b0, "R9 empty pop ignored", cell_ready_o, 0);
    drive(1, 0, 1, 9'h040);
    for (int k = 1; k < 8; k++) drive(1, 0, 0, 9'(k));
    chk(cell_ready_o == 1'b1, "R9 cell after empty pop", cell_ready_o, 1);

    // Code 0 means 128; post-reset code change ignored, R1 R10
    start_up(1, 0, 7'd0);
    size_code = 7'd5;
    for (int k = 0; k < 127; k++) drive(1, 0, (k == 0), 9'(k));
    chk(cell_ready_o == 1'b0, "R1 128-length not done at 127", cell_ready_o, 0);
    drive(1, 0, 0, 9'h07F);
    chk(cell_ready_o == 1'b1, "R1 128-length done", cell_ready_o, 1);
    chk(cav_out == 1'b0, "R10 cav_out low when full", cav_out, 0);
    pop_one();
    chk(cell_ready_o == 1'b0, "R9 pop clears ready", cell_ready_o, 0);
    chk(cav_out == 1'b1, "R10 cav_out back after pop", cav_out, 1);

    // Clamp to 8, R1
    start_up(1, 0, 7'd3);
    for (int k = 0; k < 7; k++) drive(1, 0, (k == 0), 9'(k));
    chk(cell_ready_o == 1'b0, "R1 clamp not done at 7", cell_ready_o, 0);
    drive(1, 0, 0, 9'h007);
    chk(cell_ready_o == 1'b1, "R1 clamp done at 8", cell_ready_o, 1);
    drive(1, 0, 0, 9'h008);
    chk(wr_en_o == 1'b0, "R6 excess dropped", wr_en_o, 0);

    // Default length 53, R2 R10 R8
    start_up(1, 1, 7'd8);
    for (int k = 0; k < 52; k++) drive(1, 0, (k == 0), 9'(k));
    chk(cell_ready_o == 1'b0, "R2 not done at 52", cell_ready_o, 0);
    drive(1, 0, 0, 9'h034);
    chk(cell_ready_o == 1'b1, "R2 done at 53", cell_ready_o, 1);
    chk(cav_out == 1'b1, "R10 room for second cell", cav_out, 1);
    for (int k = 0; k < 53; k++) drive(1, 0, (k == 0), 9'(k));
    chk(cav_out == 1'b0, "R10 cav_out low at 22 free", cav_out, 0);
    drive(1, 0, 1, 9'h1EE);
    chk(wr_en_o == 1'b0, "R8 start refused without cav_out", wr_en_o, 0);

    // Receive mode, length 64, R7 R10 R11
    start_up(0, 0, 7'd64);
    chk(en_out == 1'b1, "R7 en_out with room", en_out, 1);
    chk(cav_out == 1'b0, "R8 cav_out low in rx", cav_out, 0);
    drive(1, 0, 1, 9'h0EE);
    chk(wr_en_o == 1'b0, "R7 en_in ignored, no cav_in", wr_en_o, 0);
    drive(0, 1, 1, 9'h055);
    chk(wr_en_o == 1'b1, "R7 rx start", wr_en_o, 1);
    chk(wr_data_o == 9'h055, "R11 rx data", wr_data_o, 9'h055);
    for (int k = 1; k < 64; k++) drive(0, 0, 0, 9'(k));
    chk(wr_en_o == 1'b1, "R7 writes continue with cav_in low", wr_en_o, 1);
    chk(cell_ready_o == 1'b1, "R4 rx cell complete", cell_ready_o, 1);
    chk(en_out == 1'b1, "R10 en_out with 64 free", en_out, 1);
    for (int k = 0; k < 64; k++) drive(0, 1, (k == 0), 9'(k));
    chk(en_out == 1'b0, "R10 en_out low when full", en_out, 0);
    drive(0, 1, 1, 9'h1DD);
    chk(wr_en_o == 1'b0, "R7 no write with en_out low", wr_en_o, 0);
    pop_one();
    chk(en_out == 1'b1, "R10 en_out back after pop", en_out, 1);
    chk(cell_ready_o == 1'b1, "R9 one cell still held", cell_ready_o, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule